// File: doc/BRIEF.md
# Interrupt Priority Resolver

This block decides which pending interrupt, if any, the processor takes next. Each of the maskable sources raises a request line and owns a small priority level register. The block keeps those registers, and a one-cycle write port loads them. In every arbitration cycle it looks at all pending maskable requests and keeps those whose level is greatest. If several of them share that level, the one with the lowest source index wins. The winner is then compared against the processor's current priority level and the global interrupt enable. It is taken only if its level is strictly above the current level and interrupts are enabled.

Five special sources stand above every maskable source, and neither the enable nor the current priority level can block them. In falling precedence they are reset (index 0), non-maskable (index 1), watchdog (index 2), debug (index 3) and address match (index 4). The result is registered. Acceptance is signalled by a single-cycle pulse that carries the winning index and level. The block then holds that result until the core acknowledges it, or until the held request is withdrawn, and only after that does it arbitrate again.

The control is a three-state machine:
- `ST_ARB` evaluates the candidates every cycle. It moves to `ST_GRANT` when a candidate qualifies.
- `ST_GRANT` is the single pulse cycle. It returns to `ST_ARB` on an acknowledge or a withdrawal, and otherwise moves to `ST_HOLD`.
- `ST_HOLD` waits, and returns to `ST_ARB` on an acknowledge or a withdrawal.

Top module: `irq_resolver`

## Requirements
- R1: After reset every level register is 0. A maskable source whose level is 0 is never accepted, whatever its request, the enable or the current priority level.
- R2: Among pending maskable sources with non-zero level, the one with the greatest level is chosen.
- R3: When several pending maskable sources share the greatest level, the lowest source index wins.
- R4: A maskable winner is accepted only when its level is strictly greater than `cur_ipl` and `int_en` is 1. Otherwise `accept` stays 0.
- R5: A pending special source is accepted regardless of `int_en` and `cur_ipl`, and it wins over any pending maskable source. Its acceptance shows `win_special`=1 and `win_lvl` all ones.
- R6: Among pending special sources the lowest special index wins: reset 0, non-maskable 1, watchdog 2, debug 3, address match 4. `win_idx` carries that index.
- R7: `accept` rises one clock edge after the qualifying inputs are sampled and is high for exactly one cycle. `win_idx`, `win_lvl` and `win_special` are valid in that cycle and stay unchanged until acknowledge or withdrawal.
- R8: After an accept, no further accept is issued while `core_ack` stays low and the held request stays asserted.
- R9: If the held source's request drops before acknowledge, the result is dropped at the next edge. A fresh arbitration is evaluated at the edge after that.
- R10: With `lvl_wr_en`=1, the value on `lvl_wr_data` is stored into the level register of source `lvl_wr_sel` at the clock edge. It takes part in arbitration from the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NSRC | Pending flags of the maskable sources |
| sp_req | input | 5 | Pending flags of the special sources, bit n = special index n |
| lvl_wr_en | input | 1 | Level register write strobe |
| lvl_wr_sel | input | clog2(NSRC) | Source whose level is written |
| lvl_wr_data | input | LVLW | Level value to store |
| cur_ipl | input | LVLW | Processor's current interrupt priority level |
| int_en | input | 1 | Global maskable interrupt enable |
| core_ack | input | 1 | Core has taken the held result |
| accept | output | 1 | One-cycle acceptance pulse |
| win_special | output | 1 | Held winner is a special source |
| win_idx | output | clog2(NSRC) | Held winner's index |
| win_lvl | output | LVLW | Held winner's level (all ones for special) |

## Verification
On every cycle, the assertions check four things. First, an accepted maskable winner has a non-zero level above the previously sampled priority level, and interrupts were enabled. Second, a pending special request always produces a special winner. Third, the pulse lasts one cycle, the held result does not move while it waits, and a withdrawal returns the machine to arbitration. Fourth, level writes land in the selected register. Which source wins — the greatest level first, the lowest index among equals, and the exact special precedence — can only be shown by the bench's sweeps. These run every source against every level, priority level and enable, plus pseudo-random multi-request patterns compared with an arithmetic model.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

    // Number of special (non-maskable) sources and their fixed precedence.
    localparam int NUM_SPECIAL = 5;
    localparam int SP_RESET    = 0;
    localparam int SP_NMI      = 1;
    localparam int SP_WDOG     = 2;
    localparam int SP_DEBUG    = 3;
    localparam int SP_ADDR     = 4;

    typedef enum logic [1:0] {
        ST_ARB   = 2'd0,
        ST_GRANT = 2'd1,
        ST_HOLD  = 2'd2
    } res_state_e;

endpackage

// File: rtl/irq_level_bank.sv
module irq_level_bank #(
    parameter int NSRC = 32,
    parameter int LVLW = 3,
    parameter int SELW = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SELW-1:0]        wr_sel,
    input  logic [LVLW-1:0]        wr_data,
    output logic [NSRC*LVLW-1:0]   levels
);

    // One register per source, cleared by reset.
    for (genvar g = 0; g < NSRC; g++) begin : g_lvl
        logic [LVLW-1:0] lvl_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_q <= '0;
            end else if (wr_en && (wr_sel == SELW'(g))) begin
                lvl_q <= wr_data;
            end
        end

        assign levels[g*LVLW +: LVLW] = lvl_q;
    end

    // R10: a write is visible on the bank output after the edge
    a_r10_level_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_sel) < NSRC))
        |=> (levels[int'($past(wr_sel))*LVLW +: LVLW] == $past(wr_data)));

endmodule

// File: rtl/irq_maskable_pick.sv
module irq_maskable_pick #(
    parameter int NSRC = 32,
    parameter int LVLW = 3,
    parameter int IDXW = 5
) (
    input  logic [NSRC-1:0]        req,
    input  logic [NSRC*LVLW-1:0]   levels,
    output logic                   found,
    output logic [IDXW-1:0]        idx,
    output logic [LVLW-1:0]        lvl
);

    logic [NSRC-1:0] elig;

    // A source competes only when it is pending with a non-zero level.
    for (genvar g = 0; g < NSRC; g++) begin : g_elig
        assign elig[g] = req[g] && (levels[g*LVLW +: LVLW] != '0);
    end

    // Scan from the highest index down; ">=" lets a lower index
    // displace an equal level, so ties resolve toward index 0.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        lvl   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (elig[i] && (levels[i*LVLW +: LVLW] >= lvl)) begin
                found = 1'b1;
                idx   = IDXW'(i);
                lvl   = levels[i*LVLW +: LVLW];
            end
        end
    end

endmodule

// File: rtl/irq_special_pick.sv
module irq_special_pick #(
    parameter int NSP  = 5,
    parameter int IDXW = 5
) (
    input  logic [NSP-1:0]   sp_req,
    output logic             found,
    output logic [IDXW-1:0]  idx
);

    // Lowest special index has precedence.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NSP - 1; i >= 0; i--) begin
            if (sp_req[i]) begin
                found = 1'b1;
                idx   = IDXW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
    import irq_res_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int LVLW = 3,
    localparam int IDXW = $clog2(NSRC),
    localparam int NSP  = NUM_SPECIAL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_req,
    input  logic [NSP-1:0]    sp_req,
    input  logic              lvl_wr_en,
    input  logic [IDXW-1:0]   lvl_wr_sel,
    input  logic [LVLW-1:0]   lvl_wr_data,
    input  logic [LVLW-1:0]   cur_ipl,
    input  logic              int_en,
    input  logic              core_ack,
    output logic              accept,
    output logic              win_special,
    output logic [IDXW-1:0]   win_idx,
    output logic [LVLW-1:0]   win_lvl
);

    logic [NSRC*LVLW-1:0] levels;
    logic                 m_found;
    logic [IDXW-1:0]      m_idx;
    logic [LVLW-1:0]      m_lvl;
    logic                 s_found;
    logic [IDXW-1:0]      s_idx;
    logic                 mask_ok;
    logic                 cand_valid;
    logic                 held_live;
    logic                 withdrawn;
    res_state_e           state_q, state_d;

    irq_level_bank #(.NSRC(NSRC), .LVLW(LVLW), .SELW(IDXW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (lvl_wr_en),
        .wr_sel  (lvl_wr_sel),
        .wr_data (lvl_wr_data),
        .levels  (levels)
    );

    irq_maskable_pick #(.NSRC(NSRC), .LVLW(LVLW), .IDXW(IDXW)) u_mpick (
        .req    (src_req),
        .levels (levels),
        .found  (m_found),
        .idx    (m_idx),
        .lvl    (m_lvl)
    );

    irq_special_pick #(.NSP(NSP), .IDXW(IDXW)) u_spick (
        .sp_req (sp_req),
        .found  (s_found),
        .idx    (s_idx)
    );

    // Gate the maskable winner with the enable and the priority level.
    assign mask_ok    = m_found && int_en && (m_lvl > cur_ipl);
    assign cand_valid = s_found || mask_ok;

    // Is the held source still requesting?
    always_comb begin
        held_live = 1'b0;
        if (win_special) begin
            for (int i = 0; i < NSP; i++) begin
                if (win_idx == IDXW'(i)) held_live = sp_req[i];
            end
        end else begin
            for (int i = 0; i < NSRC; i++) begin
                if (win_idx == IDXW'(i)) held_live = src_req[i];
            end
        end
    end

    assign withdrawn = !held_live;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARB:   if (cand_valid) state_d = ST_GRANT;
            ST_GRANT: state_d = (core_ack || withdrawn) ? ST_ARB : ST_HOLD;
            ST_HOLD:  if (core_ack || withdrawn) state_d = ST_ARB;
            default:  state_d = ST_ARB;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ARB;
        else        state_q <= state_d;
    end

    // Result register, loaded only when a decision is made.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_special <= 1'b0;
            win_idx     <= '0;
            win_lvl     <= '0;
        end else if ((state_q == ST_ARB) && cand_valid) begin
            if (s_found) begin
                win_special <= 1'b1;
                win_idx     <= s_idx;
                win_lvl     <= '1;
            end else begin
                win_special <= 1'b0;
                win_idx     <= m_idx;
                win_lvl     <= m_lvl;
            end
        end
    end

    // Outputs
    always_comb begin
        accept = (state_q == ST_GRANT);
    end

    // R1: a maskable acceptance never carries level 0
    a_r1_nonzero_level: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !win_special) |-> (win_lvl != '0));

    // R4: a maskable acceptance required enable and a level above IPL
    a_r4_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !win_special) |-> ((win_lvl > $past(cur_ipl)) && $past(int_en)));

    // R5: a pending special request at decision time yields a special winner
    a_r5_special_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ($past(sp_req) != '0)) |-> win_special);

    // R7: the acceptance pulse lasts exactly one cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);

    // R8: while waiting, the held result does not change
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_ARB) && !core_ack && !withdrawn)
        |=> ($stable(win_idx) && $stable(win_lvl) && $stable(win_special) && !accept));

    // R9: a withdrawn request sends the machine back to arbitration
    a_r9_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_ARB) && withdrawn) |=> ((state_q == ST_ARB) && !accept));

endmodule

// File: tb/irq_resolver_test.sv
`timescale 1ns/1ps
module irq_resolver_test;

    localparam int NSRC = 32;
    localparam int LVLW = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_req = '0;
    logic [4:0]  sp_req = '0;
    logic        lvl_wr_en = 1'b0;
    logic [4:0]  lvl_wr_sel = '0;
    logic [2:0]  lvl_wr_data = '0;
    logic [2:0]  cur_ipl = '0;
    logic        int_en = 1'b0;
    logic        core_ack = 1'b0;
    logic        accept;
    logic        win_special;
    logic [4:0]  win_idx;
    logic [2:0]  win_lvl;

    int n_cmp = 0;
    int n_bad = 0;
    int lv [NSRC];
    logic [31:0] rng = 32'h1234_5678;
    bit done = 0;

    always #2 clk = ~clk;

    irq_resolver #(.NSRC(NSRC), .LVLW(LVLW)) uut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .sp_req(sp_req),
        .lvl_wr_en(lvl_wr_en), .lvl_wr_sel(lvl_wr_sel), .lvl_wr_data(lvl_wr_data),
        .cur_ipl(cur_ipl), .int_en(int_en), .core_ack(core_ack),
        .accept(accept), .win_special(win_special), .win_idx(win_idx), .win_lvl(win_lvl)
    );

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rng(logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13;
        x ^= x >> 17;
        x ^= x << 5;
        return x;
    endfunction

    task automatic set_lvl(int i, int l);
        @(negedge clk);
        lvl_wr_en   = 1'b1;
        lvl_wr_sel  = 5'(i);
        lvl_wr_data = 3'(l);
        @(negedge clk);
        lvl_wr_en = 1'b0;
        lv[i] = l;
    endtask

    // Independent model of the decision
    task automatic model(input logic [31:0] r, input logic [4:0] s, input int ipl, input bit en,
                         output bit v, output bit sp, output int idx, output int l);
        int best;
        v = 0; sp = 0; idx = 0; l = 0;
        if (s != 0) begin
            for (int i = 4; i >= 0; i--) if (s[i]) idx = i;
            v = 1; sp = 1; l = 7;
            return;
        end
        best = 0;
        for (int i = 0; i < NSRC; i++) begin
            if (r[i] && lv[i] > best) begin
                best = lv[i];
                idx = i;
            end
        end
        l = best;
        v = (best > 0) && en && (best > ipl);
    endtask

    // Apply a pattern at a negedge, check one edge later, then ack and clear.
    task automatic trial(string tag, logic [31:0] r, logic [4:0] s, int ipl, bit en);
        bit v, sp;
        int idx, l;
        model(r, s, ipl, en, v, sp, idx, l);
        @(negedge clk);
        src_req = r; sp_req = s; cur_ipl = 3'(ipl); int_en = en;
        @(negedge clk);
        chk({tag, " accept"}, int'(accept), int'(v));
        if (v) begin
            chk({tag, " special"}, int'(win_special), int'(sp));
            chk({tag, " idx"}, int'(win_idx), idx);
            chk({tag, " lvl"}, int'(win_lvl), l);
            core_ack = 1'b1;
        end
        src_req = '0; sp_req = '0;
        @(negedge clk);
        core_ack = 1'b0;
        chk({tag, " quiet"}, int'(accept), 0);
    endtask

    initial begin
        for (int i = 0; i < NSRC; i++) lv[i] = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset accept", int'(accept), 0);
        rst_n = 1'b1;

        // R1: all levels zero, everything pending, fully enabled
        @(negedge clk);
        src_req = '1; int_en = 1'b1; cur_ipl = '0;
        repeat (3) begin
            @(negedge clk);
            chk("R1 zero level blocked", int'(accept), 0);
        end
        src_req = '0;
        @(negedge clk);

        // R4 / R10: every source, every level, every IPL and enable
        for (int i = 0; i < NSRC; i++) begin
            for (int l = 1; l < 8; l++) begin
                set_lvl(i, l);
                for (int p = 0; p < 8; p++)
                    for (int e = 0; e < 2; e++)
                        trial("R4 R10 sweep", 32'(1) << i, 5'd0, p, bit'(e));
            end
            set_lvl(i, 0);
        end

        // R3: tie goes to lower index; R2: greater level wins
        set_lvl(5, 4); set_lvl(9, 4);
        trial("R3 tie", (32'(1) << 5) | (32'(1) << 9), 5'd0, 0, 1'b1);
        set_lvl(9, 6);
        trial("R2 higher level", (32'(1) << 5) | (32'(1) << 9), 5'd0, 0, 1'b1);
        set_lvl(5, 0); set_lvl(9, 0);

        // R5 / R6: every special combination over a pending maskable source
        set_lvl(0, 7);
        for (int s = 1; s < 32; s++) begin
            trial("R5 R6 special en", '1, 5'(s), 0, 1'b1);
            trial("R5 R6 special masked", '1, 5'(s), 7, 1'b0);
        end
        set_lvl(0, 0);

        // R2 / R3 / R4: pseudo-random multi-request patterns
        for (int t = 0; t < 250; t++) begin
            logic [31:0] r;
            logic [4:0]  s;
            int p;
            bit e;
            for (int i = 0; i < NSRC; i++) begin
                rng = next_rng(rng);
                set_lvl(i, int'(rng[2:0]));
            end
            rng = next_rng(rng); r = rng;
            rng = next_rng(rng); p = int'(rng[2:0]); e = rng[3];
            s = (rng[9:8] == 2'b00) ? rng[14:10] : 5'd0;
            trial("R2 R3 random", r, s, p, e);
        end
        for (int i = 0; i < NSRC; i++) set_lvl(i, 0);

        // R7 / R8: no ack, held request -> single pulse, stable result
        set_lvl(3, 5);
        @(negedge clk);
        src_req = 32'(1) << 3; int_en = 1'b1; cur_ipl = 3'd1;
        @(negedge clk);
        chk("R7 pulse", int'(accept), 1);
        chk("R7 idx", int'(win_idx), 3);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R8 no re-accept", int'(accept), 0);
            chk("R7 idx held", int'(win_idx), 3);
            chk("R7 lvl held", int'(win_lvl), 5);
        end
        core_ack = 1'b1; src_req = '0;
        @(negedge clk);
        core_ack = 1'b0;
        chk("R8 after ack", int'(accept), 0);

        // R9: withdraw the held source, a lower one takes over
        set_lvl(10, 2);
        @(negedge clk);
        src_req = (32'(1) << 3) | (32'(1) << 10); cur_ipl = 3'd0;
        @(negedge clk);
        chk("R9 first accept", int'(accept), 1);
        chk("R9 first idx", int'(win_idx), 3);
        src_req = 32'(1) << 10;
        @(negedge clk);
        chk("R9 dropped", int'(accept), 0);
        @(negedge clk);
        chk("R9 re-arbitrated", int'(accept), 1);
        chk("R9 new idx", int'(win_idx), 10);
        chk("R9 new lvl", int'(win_lvl), 2);
        core_ack = 1'b1; src_req = '0;
        @(negedge clk);
        core_ack = 1'b0;

        // R9 with a special source withdrawn
        @(negedge clk);
        sp_req = 5'b00100;
        @(negedge clk);
        chk("R9 special idx", int'(win_idx), 2);
        sp_req = 5'b00000;
        @(negedge clk);
        chk("R9 special dropped", int'(accept), 0);
        @(negedge clk);
        chk("R9 nothing left", int'(accept), 0);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule